// File: doc/BRIEF.md
# Pointer-Redirected Data Memory Access Unit

This block resolves the data memory target for an 8-bit processor and carries out the access against a 4096 x 8 synchronous RAM with one port. An operand is given as an 8-bit offset plus an access-bank flag. A direct operand takes its upper address nibble from a 4-bit bank select register. When the access-bank flag is set, the operand instead maps into a low window at the bottom of memory or a high window at the top of memory. The pointer registers, the bank select register and three virtual operand registers all live in the high window.

The block holds three 12-bit pointer registers, and each pointer is split into a low byte and a high byte. When the resolved operand is one of the three virtual operand addresses, the access goes instead to the RAM byte whose address is held in the matching pointer. Bank select and the access-bank flag then play no part in forming the target. The virtual registers hold no data of their own. A pointer that holds the address of a virtual register gives a null access.

Each request takes one cycle to issue. One cycle later the block reports completion, the final resolved address and the read data. A read-modify-write is carried out as a read followed by a write through the same operand, so both halves reach the same location.

Top module: `ptr_dmem_unit`

## Requirements
- R1: After reset, all three pointers and the bank select register read back as 00h. acc_done is low until the first request.
- R2: The pointer bytes sit at special addresses. FE0h/FE1h hold pointer 0 low/high, FE2h/FE3h hold pointer 1 low/high, and FE4h/FE5h hold pointer 2 low/high. A write updates one byte. On a high byte, only bits 3:0 are stored, and bits 7:4 read back as zero.
- R3: With acc_abank=0, the operand address is {bank_select[3:0], acc_ofs[7:0]}. Bank select is written and read at FE6h, using bits 3:0, and reads back with bits 7:4 as zero.
- R4: With acc_abank=1, offsets 00h-5Fh resolve to 000h-05Fh and offsets 60h-FFh resolve to F60h-FFFh.
- R5: Operand addresses FE8h, FE9h and FEAh are virtual registers 0, 1 and 2. A read through virtual register n returns the RAM byte at pointer n. A write stores acc_wdata at that address. acc_addr reports the pointer value.
- R6: For a virtual operand, the target depends only on the pointer. Reaching FE9h through bank select F gives the same target as reaching it through acc_abank=1, whatever the value of bank select.
- R7: If a pointer holds a virtual register address (FE8h-FEAh), a read through it returns 00h. A write through it changes no RAM byte and no register.
- R8: acc_done rises exactly one cycle after each request with acc_en=1, and only then. acc_addr and rd_data (for reads) are valid in that same cycle.
- R9: Pointer 1 = FCCh is the worked case. A read through virtual register 1, followed by a write of the incremented value through it, updates location FCCh.
- R10: A pointer that holds a pointer or bank select address accesses that register. Writing through a virtual register whose pointer holds FE3h sets the high byte of pointer 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Request strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_abank | input | 1 | Access-bank flag for operand mapping |
| acc_ofs | input | 8 | Operand offset |
| acc_wdata | input | 8 | Write data |
| acc_done | output | 1 | Completion, one cycle after a request |
| acc_addr | output | 12 | Final resolved target address |
| rd_data | output | 8 | Read result |

## Verification
On every cycle, the assertions check the following:
- completion timing
- the two access-bank windows
- direct banked address formation
- the pointer-only target of a virtual operand
- zero data on null reads
- pointer stability when no write is made

Some behaviours depend on memory contents and the history of register writes, so only the bench scenarios can show them. These are:
- that RAM data really lands at the pointed address
- that null writes leave every location intact
- high-byte truncation
- pointer-to-register redirection
- the read-modify-write at FCCh

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  // Source of the read data selected in the response stage
  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_REG  = 2'd1,
    SRC_ZERO = 2'd2
  } src_e;
endpackage

// File: rtl/pdm_ram.sv
module pdm_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, read-first, registered output for block RAM inference
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/pdm_ptr_file.sv
module pdm_ptr_file #(
  parameter int          NPTR      = 3,
  parameter int          AW        = 12,
  parameter int          DW        = 8,
  parameter int          BANK_W    = 4,
  parameter int unsigned PTR_BASE  = 'hFE0,
  parameter int unsigned BSEL_ADDR = 'hFE6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic               rd_hit,
  output logic [DW-1:0]      rd_val,
  output logic [NPTR*AW-1:0] ptr_flat,
  output logic [BANK_W-1:0]  bsel
);
  localparam int HI_W = AW - DW;
  localparam logic [AW-1:0] BSEL_A = AW'(BSEL_ADDR);

  logic [DW-1:0]     lo_q [NPTR];
  logic [HI_W-1:0]   hi_q [NPTR];
  logic [BANK_W-1:0] bsel_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [AW-1:0] LO_A = AW'(PTR_BASE + 2 * g);
    localparam logic [AW-1:0] HI_A = AW'(PTR_BASE + 2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == LO_A) lo_q[g] <= wr_data;
        if (wr_addr == HI_A) hi_q[g] <= wr_data[HI_W-1:0];
      end
    end

    assign ptr_flat[g*AW +: AW] = {hi_q[g], lo_q[g]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsel_q <= '0;
    end else if (wr_en && wr_addr == BSEL_A) begin
      bsel_q <= wr_data[BANK_W-1:0];
    end
  end

  assign bsel = bsel_q;

  // Register read decode; unimplemented high bits return zero
  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (rd_addr == AW'(PTR_BASE + 2 * i)) begin
        rd_hit = 1'b1;
        rd_val = lo_q[i];
      end
      if (rd_addr == AW'(PTR_BASE + 2 * i + 1)) begin
        rd_hit = 1'b1;
        rd_val = DW'(hi_q[i]);
      end
    end
    if (rd_addr == BSEL_A) begin
      rd_hit = 1'b1;
      rd_val = DW'(bsel_q);
    end
  end
endmodule

// File: rtl/pdm_resolve.sv
module pdm_resolve #(
  parameter int          NPTR      = 3,
  parameter int          BANK_W    = 4,
  parameter int          OFS_W     = 8,
  parameter int unsigned ACC_SPLIT = 'h60,
  parameter int unsigned VIRT_BASE = 'hFE8,
  localparam int         AW        = BANK_W + OFS_W
) (
  input  logic               abank,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [BANK_W-1:0]  bsel,
  input  logic [NPTR*AW-1:0] ptr_flat,
  output logic [AW-1:0]      tgt,
  output logic               ind,
  output logic               nul
);
  localparam logic [OFS_W-1:0] SPLIT = OFS_W'(ACC_SPLIT);

  logic [AW-1:0] op_addr;
  logic [AW-1:0] ptr_sel;

  // Stage 1: operand address from banking or the access-bank windows
  always_comb begin
    if (abank) begin
      if (ofs < SPLIT) op_addr = {{BANK_W{1'b0}}, ofs};
      else             op_addr = {{BANK_W{1'b1}}, ofs};
    end else begin
      op_addr = {bsel, ofs};
    end
  end

  // Stage 2: virtual operand substitutes the full-width pointer
  always_comb begin
    ind     = 1'b0;
    ptr_sel = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (op_addr == AW'(VIRT_BASE + i)) begin
        ind     = 1'b1;
        ptr_sel = ptr_flat[i*AW +: AW];
      end
    end
  end

  // Stage 3: a pointer aimed at a virtual register yields a null access
  always_comb begin
    nul = 1'b0;
    if (ind) begin
      for (int i = 0; i < NPTR; i++) begin
        if (ptr_sel == AW'(VIRT_BASE + i)) nul = 1'b1;
      end
    end
    tgt = ind ? ptr_sel : op_addr;
  end
endmodule

// File: rtl/ptr_dmem_unit.sv
module ptr_dmem_unit #(
  parameter int          NPTR      = 3,
  parameter int          BANK_W    = 4,
  parameter int          OFS_W     = 8,
  parameter int          DW        = 8,
  parameter int unsigned ACC_SPLIT = 'h60,
  parameter int unsigned PTR_BASE  = 'hFE0,
  parameter int unsigned BSEL_ADDR = 'hFE6,
  parameter int unsigned VIRT_BASE = 'hFE8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_en,
  input  logic                    acc_we,
  input  logic                    acc_abank,
  input  logic [OFS_W-1:0]        acc_ofs,
  input  logic [DW-1:0]           acc_wdata,
  output logic                    acc_done,
  output logic [BANK_W+OFS_W-1:0] acc_addr,
  output logic [DW-1:0]           rd_data
);
  import pdm_pkg::*;

  localparam int AW = BANK_W + OFS_W;

  logic [AW-1:0]      tgt;
  logic               ind;
  logic               nul;
  logic [NPTR*AW-1:0] ptr_flat;
  logic [BANK_W-1:0]  bsel;
  logic               reg_hit;
  logic [DW-1:0]      reg_val;
  logic               ram_en;
  logic               ram_we;
  logic [DW-1:0]      ram_q;

  logic               done_q;
  logic [AW-1:0]      addr_q;
  logic               nul_q;
  logic               ind_q;
  src_e               src_q;
  logic [DW-1:0]      reg_q;

  pdm_resolve #(
    .NPTR(NPTR), .BANK_W(BANK_W), .OFS_W(OFS_W),
    .ACC_SPLIT(ACC_SPLIT), .VIRT_BASE(VIRT_BASE)
  ) u_res (
    .abank(acc_abank), .ofs(acc_ofs), .bsel(bsel), .ptr_flat(ptr_flat),
    .tgt(tgt), .ind(ind), .nul(nul)
  );

  pdm_ptr_file #(
    .NPTR(NPTR), .AW(AW), .DW(DW), .BANK_W(BANK_W),
    .PTR_BASE(PTR_BASE), .BSEL_ADDR(BSEL_ADDR)
  ) u_ptr (
    .clk(clk), .rst(rst),
    .wr_en(acc_en && acc_we && !nul), .wr_addr(tgt), .wr_data(acc_wdata),
    .rd_addr(tgt), .rd_hit(reg_hit), .rd_val(reg_val),
    .ptr_flat(ptr_flat), .bsel(bsel)
  );

  assign ram_en = acc_en && !nul && !reg_hit;
  assign ram_we = ram_en && acc_we;

  pdm_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(tgt),
    .wdata(acc_wdata), .rdata(ram_q)
  );

  // Response stage, aligned with the RAM read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      addr_q <= '0;
      nul_q  <= 1'b0;
      ind_q  <= 1'b0;
      src_q  <= SRC_ZERO;
      reg_q  <= '0;
    end else begin
      done_q <= acc_en;
      if (acc_en) begin
        addr_q <= tgt;
        nul_q  <= nul;
        ind_q  <= ind;
        reg_q  <= reg_val;
        if (nul)          src_q <= SRC_ZERO;
        else if (reg_hit) src_q <= SRC_REG;
        else              src_q <= SRC_RAM;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM: rd_data = ram_q;
      SRC_REG: rd_data = reg_q;
      default: rd_data = '0;
    endcase
  end

  assign acc_done = done_q;
  assign acc_addr = addr_q;
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker (
  input logic        clk,
  input logic        rst,
  input logic        acc_en,
  input logic        acc_we,
  input logic        acc_abank,
  input logic [7:0]  acc_ofs,
  input logic        acc_done,
  input logic [11:0] acc_addr,
  input logic [7:0]  rd_data,
  input logic        nul_q,
  input logic [35:0] ptr_flat,
  input logic [3:0]  bsel
);
  // R8: completion exactly one cycle after each request
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (acc_done == $past(acc_en)));

  // R4: lower access-bank window
  a_r4_low_window: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && acc_abank && acc_ofs < 8'h60))
      |-> (acc_addr == {4'h0, $past(acc_ofs)}));

  // R4: upper access-bank window (non-virtual offsets)
  a_r4_high_window: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && acc_abank && acc_ofs >= 8'h60
                          && (acc_ofs < 8'hE8 || acc_ofs > 8'hEA)))
      |-> (acc_addr == {4'hF, $past(acc_ofs)}));

  // R3: banked direct address
  a_r3_banked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && !acc_abank && bsel != 4'hF))
      |-> (acc_addr == {$past(bsel), $past(acc_ofs)}));

  // R6: virtual register 1 target is pointer 1 regardless of banking
  a_r6_ptr_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && acc_ofs == 8'hE9 && (acc_abank || bsel == 4'hF)))
      |-> (acc_addr == $past(ptr_flat[23:12])));

  // R7: null read returns zero
  a_r7_null_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_done && nul_q && !$past(acc_we)) |-> (rd_data == 8'h00));

  // R2: pointers only change on a write request
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_en && acc_we)) |-> $stable(ptr_flat));

  // R1: reset clears pointers and bank select
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ptr_flat == 36'h0 && bsel == 4'h0));
endmodule

bind ptr_dmem_unit pdm_checker u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
  .acc_abank(acc_abank), .acc_ofs(acc_ofs), .acc_done(acc_done),
  .acc_addr(acc_addr), .rd_data(rd_data), .nul_q(nul_q),
  .ptr_flat(ptr_flat), .bsel(bsel)
);

// File: tb/ptr_dmem_unit_tb.sv
`timescale 1ns/1ps
module ptr_dmem_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0, acc_we = 1'b0, acc_abank = 1'b0;
  logic [7:0] acc_ofs = 8'h00, acc_wdata = 8'h00;
  logic       acc_done;
  logic [11:0] acc_addr;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit summary_done = 1'b0;

  logic [7:0]  mem [4096];
  bit          known [4096];
  logic [11:0] mp [3];
  logic [3:0]  mb;
  logic [7:0]  last_rd;

  always #2 clk = ~clk;

  ptr_dmem_unit u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_abank(acc_abank), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .acc_addr(acc_addr), .rd_data(rd_data)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string rq);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [11:0] m_op(input bit ab, input logic [7:0] o);
    if (ab) return (o < 8'h60) ? {4'h0, o} : {4'hF, o};
    return {mb, o};
  endfunction

  function automatic bit is_virt(input logic [11:0] a);
    return a >= 12'hFE8 && a <= 12'hFEA;
  endfunction

  // One access; checks done, address and (for reads) data against the model
  task automatic acc(input bit we, input bit ab, input logic [7:0] o,
                     input logic [7:0] wd, input string rq);
    logic [11:0] op, t;
    bit nul, dchk;
    logic [7:0] ed;
    int idx;
    op = m_op(ab, o);
    t = op; nul = 1'b0;
    if (is_virt(op)) begin
      t = mp[op - 12'hFE8];
      nul = is_virt(t);
    end
    dchk = 1'b1; ed = 8'h00;
    if (nul) ed = 8'h00;
    else if (t >= 12'hFE0 && t <= 12'hFE5) begin
      idx = int'(t - 12'hFE0) >> 1;
      ed = t[0] ? {4'h0, mp[idx][11:8]} : mp[idx][7:0];
    end else if (t == 12'hFE6) ed = {4'h0, mb};
    else if (known[t]) ed = mem[t];
    else dchk = 1'b0;

    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_abank = ab; acc_ofs = o; acc_wdata = wd;
    @(negedge clk);
    acc_en = 1'b0;
    chk({15'h0, acc_done}, 16'h1, {rq, " R8 done"});
    chk({4'h0, acc_addr}, {4'h0, t}, {rq, " addr"});
    if (!we && dchk) chk({8'h0, rd_data}, {8'h0, ed}, {rq, " data"});
    last_rd = rd_data;

    if (we && !nul) begin
      if (t >= 12'hFE0 && t <= 12'hFE5) begin
        idx = int'(t - 12'hFE0) >> 1;
        if (t[0]) mp[idx][11:8] = wd[3:0];
        else      mp[idx][7:0]  = wd;
      end else if (t == 12'hFE6) mb = wd[3:0];
      else begin
        mem[t] = wd;
        known[t] = 1'b1;
      end
    end
  endtask

  task automatic setp(input int n, input logic [11:0] v);
    acc(1'b1, 1'b1, 8'(8'hE0 + 2 * n), v[7:0], "setp");
    acc(1'b1, 1'b1, 8'(8'hE1 + 2 * n), {4'hA, v[11:8]}, "setp");
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd24680);
    for (int i = 0; i < 4096; i++) begin known[i] = 1'b0; mem[i] = 8'h00; end
    for (int i = 0; i < 3; i++) mp[i] = 12'h000;
    mb = 4'h0; last_rd = 8'h00;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk({15'h0, acc_done}, 16'h0, "R1 done low after reset");
    for (int i = 0; i < 7; i++) acc(1'b0, 1'b1, 8'(8'hE0 + i), 8'h00, "R1 reset regs");

    // R2: high byte truncation
    acc(1'b1, 1'b1, 8'hE1, 8'hFF, "R2 wr hi");
    acc(1'b0, 1'b1, 8'hE1, 8'h00, "R2 rd hi");
    chk({8'h0, last_rd}, 16'h000F, "R2 hi upper zero");

    // R3: banked direct access
    acc(1'b1, 1'b1, 8'hE6, 8'hF3, "R3 bsel");
    acc(1'b1, 1'b0, 8'h10, 8'h77, "R3 wr 310");
    acc(1'b0, 1'b1, 8'hE6, 8'h00, "R3 rd bsel");
    chk({8'h0, last_rd}, 16'h0003, "R3 bsel upper zero");

    // R4: window edges
    acc(1'b1, 1'b1, 8'h5F, 8'h11, "R4 5F");
    acc(1'b1, 1'b1, 8'h60, 8'h22, "R4 60");
    acc(1'b0, 1'b1, 8'h5F, 8'h00, "R4 rd 5F");
    acc(1'b0, 1'b1, 8'h60, 8'h00, "R4 rd 60");

    // R5 / R9: pointer 1 = FCCh, read-modify-write through virtual 1
    setp(1, 12'hFCC);
    acc(1'b1, 1'b1, 8'hE9, 8'h5A, "R5 wr virt1");
    acc(1'b0, 1'b1, 8'hCC, 8'h00, "R5 rd FCC direct");
    acc(1'b0, 1'b1, 8'hE9, 8'h00, "R9 rmw read");
    acc(1'b1, 1'b1, 8'hE9, last_rd + 8'h01, "R9 rmw write");
    acc(1'b0, 1'b1, 8'hCC, 8'h00, "R9 rd FCC");
    chk({8'h0, last_rd}, 16'h005B, "R9 FCC incremented");

    // R6: same target via bank select F, bank select ignored
    acc(1'b1, 1'b1, 8'hE6, 8'h0F, "R6 bsel F");
    acc(1'b0, 1'b0, 8'hE9, 8'h00, "R6 virt via bank F");
    chk({8'h0, last_rd}, 16'h005B, "R6 data");
    acc(1'b1, 1'b1, 8'hE6, 8'h07, "R6 bsel 7");
    acc(1'b0, 1'b1, 8'hE9, 8'h00, "R6 virt bsel 7");

    // R7: pointer 2 aims at virtual 0 whose pointer aims at a RAM byte
    setp(0, 12'h123);
    acc(1'b1, 1'b1, 8'hE8, 8'h3C, "R7 seed 123");
    setp(2, 12'hFE8);
    acc(1'b0, 1'b1, 8'hEA, 8'h00, "R7 null read");
    acc(1'b1, 1'b1, 8'hEA, 8'hC3, "R7 null write");
    acc(1'b0, 1'b1, 8'hE8, 8'h00, "R7 123 unchanged");
    chk({8'h0, last_rd}, 16'h003C, "R7 no double redirect");

    // R10: pointer aimed at pointer 1 high byte
    setp(0, 12'hFE3);
    acc(1'b1, 1'b1, 8'hE8, 8'h0B, "R10 wr via ptr");
    acc(1'b0, 1'b1, 8'hE3, 8'h00, "R10 rd p1 hi");
    chk({8'h0, last_rd}, 16'h000B, "R10 p1 hi set");

    // Random mix, biased toward special registers and virtual operands
    for (int k = 0; k < 900; k++) begin
      int unsigned r;
      logic [7:0] o;
      bit ab;
      r = $urandom % 8;
      ab = 1'b1;
      case (r)
        0, 1: o = 8'(8'hE8 + ($urandom % 3));
        2: o = 8'(8'hE0 + ($urandom % 7));
        3: begin ab = 1'b0; o = 8'($urandom); end
        default: o = 8'($urandom);
      endcase
      if (r == 2 && ($urandom % 4) == 0)
        setp(int'($urandom % 3), 12'(12'hFE0 + ($urandom % 11)));
      else if (r == 2)
        setp(int'($urandom % 3), 12'($urandom));
      else
        acc(1'($urandom), ab, o, 8'($urandom), "R5 random");
    end

    @(negedge clk);
    chk({15'h0, acc_done}, 16'h0, "R8 idle done low");
    finish_run();
  end
endmodule